// File: doc/BRIEF.md
# Buffered Block-Copy Engine

This block copies a run of 32-bit words in one direction between a private 4 KiB word buffer and external memory. The buffer sits as a fixed window in the engine's transfer address space. The host programs a source address, a destination address, a byte count and a command word through a small register port. A command that carries the run bit arms the engine. After a fixed number of cycles set by a parameter, the engine checks that the buffer-side range lies inside the window. It then moves the words over a request/acknowledge master port, one word per handshake.

The direction bit picks the copy. In the inbound direction, external memory at the source is copied into the buffer at the destination. In the outbound direction, the buffer at the source is copied out to external memory at the destination. Every address driven on the external side has its upper bits cleared above a parameterised mask width. While the run bit is set, the four registers cannot be changed. When the copy ends, the run bit drops and, if asked, a one-cycle interrupt pulse marks completion. If the buffer-side range does not fit the window, the engine abandons the copy, moves nothing, raises an error flag and drops the run bit.

Top module: `dma_lbuf_engine`

## Requirements
- R1: Registers sit at byte offsets 0x80 (source), 0x88 (destination), 0x90 (count) and 0x98 (command), and reading an offset returns the stored value. A 64-bit access (`reg_wide`=1) stores all 64 bits. A 32-bit access (`reg_wide`=0) stores the low 32 bits and clears the upper half. Any other offset reads as all ones.
- R2: While command bit 0 (run) reads 1, writes to all four registers are discarded, and reads keep working.
- R3: A command write whose data has bit 0 clear is discarded. An accepted command write sets run, stores bit 1 (direction) and bit 2 (interrupt enable), and clears the error flag in bit 31. All other command bits read as 0.
- R4: Counting the cycle in which the command write is accepted as cycle 0, the first `mem_req` appears in cycle START_DELAY+2 and not before.
- R5: Direction 0 copies external words starting at the source address into the buffer starting at the destination address.
- R6: Direction 1 copies buffer words starting at the source address to external memory starting at the destination address.
- R7: The buffer occupies transfer addresses 0x40000 to 0x40FFF. A copy is accepted only when the buffer-side start lies in that window, the word-rounded count is nonzero, and start plus count does not pass 0x41000. A range ending exactly at 0x41000 is accepted.
- R8: A rejected range raises no `mem_req`, clears run, and sets command bit 31.
- R9: Every external address on `mem_addr` is the programmed address plus the word offset, ANDed with a mask of EXT_MASK_W low ones (default 28, i.e. 0x0FFFFFFF).
- R10: A finished copy clears run. `dma_irq` pulses for one cycle at completion when bit 2 was set, and never otherwise.
- R11: Count bits 1:0 and buffer-address bits 1:0 are ignored, so exactly count/4 (rounded down) words are moved.
- R12: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay steady until `mem_ack`. A word completes in the cycle where request and acknowledge are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1: 64-bit access, 0: 32-bit access |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| mem_req | output | 1 | External word request |
| mem_we | output | 1 | 1: write to external memory, 0: read |
| mem_addr | output | 64 | Masked external byte address |
| mem_wdata | output | 32 | Word written to external memory |
| mem_ack | input | 1 | External acknowledge |
| mem_rdata | input | 32 | Word read from external memory |
| dma_irq | output | 1 | One-cycle completion interrupt pulse |

## Verification
The hardest case to reach from the ports is a write that lands while run is set. Such a write only matters during the delay window or a stalled copy, and its effect can only be seen by reading back the registers before the copy ends. The stimulus arms an outbound copy and, within the START_DELAY cycles before the first request, writes a new source value and a second command. It then reads back both registers to check they are unchanged. Buffer contents cannot be read directly, so every inbound copy is later confirmed by an outbound copy of the same words. The expected words come from a bench-side model of the buffer.

// File: rtl/dma_lbuf_pkg.sv
package dma_lbuf_pkg;
  localparam int XA_W = 64;
  typedef logic [XA_W-1:0] xaddr_t;

  // register offsets: host software depends on these positions
  localparam logic [7:0] OFF_SRC = 8'h80;
  localparam logic [7:0] OFF_DST = 8'h88;
  localparam logic [7:0] OFF_CNT = 8'h90;
  localparam logic [7:0] OFF_CMD = 8'h98;

  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 1;
  localparam int CMD_IEN = 2;
  localparam int CMD_ERR = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_CHECK, ST_MOVE, ST_FIN
  } seq_state_e;

  // byte count rounded down to whole words
  function automatic xaddr_t word_bytes(xaddr_t cnt);
    return {cnt[XA_W-1:2], 2'b00};
  endfunction

  // buffer-side range test, written to avoid overflow of start+count
  function automatic logic range_ok(xaddr_t start, xaddr_t nbytes,
                                    xaddr_t base, xaddr_t size);
    xaddr_t lim;
    xaddr_t s;
    lim = base + size;
    s   = {start[XA_W-1:2], 2'b00};
    return (nbytes != '0) && (s >= base) && (s < lim) && (nbytes <= lim - s);
  endfunction

  // keep only the low w bits of an external address
  function automatic xaddr_t ext_mask(xaddr_t a, int unsigned w);
    if (w >= XA_W) return a;
    return a & ((xaddr_t'(1) << w) - xaddr_t'(1));
  endfunction
endpackage

// File: rtl/dma_lbuf_ram.sv
module dma_lbuf_ram #(
  parameter int WORDS = 1024,
  parameter int IDX_W = 10,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/dma_lbuf_regs.sv
module dma_lbuf_regs
  import dma_lbuf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_wide,
  input  logic [7:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  input  logic        ev_done,
  input  logic        ev_abort,
  output xaddr_t      src_q,
  output xaddr_t      dst_q,
  output xaddr_t      cnt_q,
  output logic        run_q,
  output logic        dir_q,
  output logic        ien_q,
  output logic        err_q,
  output logic        ev_start
);
  logic [63:0] wval;
  logic        wr_open;
  logic [63:0] cmd_view;

  assign wval     = reg_wide ? reg_wdata : {32'h0, reg_wdata[31:0]};
  assign wr_open  = reg_wr && !run_q;
  assign ev_start = wr_open && (reg_addr == OFF_CMD) && reg_wdata[CMD_RUN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (wr_open) begin
      if (reg_addr == OFF_SRC) src_q <= wval;
      if (reg_addr == OFF_DST) dst_q <= wval;
      if (reg_addr == OFF_CNT) cnt_q <= wval;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dir_q <= 1'b0;
      ien_q <= 1'b0;
      err_q <= 1'b0;
    end else if (ev_start) begin
      run_q <= 1'b1;
      dir_q <= reg_wdata[CMD_DIR];
      ien_q <= reg_wdata[CMD_IEN];
      err_q <= 1'b0;
    end else if (ev_done) begin
      run_q <= 1'b0;
    end else if (ev_abort) begin
      run_q <= 1'b0;
      err_q <= 1'b1;
    end
  end

  always_comb begin
    cmd_view          = '0;
    cmd_view[CMD_RUN] = run_q;
    cmd_view[CMD_DIR] = dir_q;
    cmd_view[CMD_IEN] = ien_q;
    cmd_view[CMD_ERR] = err_q;
  end

  always_comb begin
    case (reg_addr)
      OFF_SRC: reg_rdata = src_q;
      OFF_DST: reg_rdata = dst_q;
      OFF_CNT: reg_rdata = cnt_q;
      OFF_CMD: reg_rdata = cmd_view;
      default: reg_rdata = '1;
    endcase
  end
endmodule

// File: rtl/dma_lbuf_seq.sv
module dma_lbuf_seq
  import dma_lbuf_pkg::*;
#(
  parameter int     START_DELAY = 16,
  parameter xaddr_t BUF_BASE    = 64'h40000,
  parameter int     BUF_BYTES   = 4096,
  parameter int     EXT_MASK_W  = 28,
  parameter int     IDX_W       = 10,
  parameter int     DLY_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start,
  input  logic             dir,
  input  logic             ien,
  input  xaddr_t           src,
  input  xaddr_t           dst,
  input  xaddr_t           cnt,
  output logic             mem_req,
  output logic             mem_we,
  output xaddr_t           mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_idx,
  output logic [31:0]      buf_wdata,
  input  logic [31:0]      buf_rdata,
  output logic             ev_done,
  output logic             ev_abort,
  output logic             irq
);
  localparam int IW1 = IDX_W + 1;

  seq_state_e       st;
  logic [DLY_W-1:0] dly;
  logic [IDX_W:0]   widx;
  xaddr_t           nbytes;
  xaddr_t           ext_base;
  xaddr_t           buf_start;
  logic             win_ok;
  logic [IDX_W-1:0] buf_first;
  logic [IDX_W:0]   last_idx;
  logic             word_fire;

  assign nbytes    = word_bytes(cnt);
  assign ext_base  = dir ? dst : src;
  assign buf_start = dir ? src : dst;
  assign win_ok    = range_ok(buf_start, nbytes, BUF_BASE, xaddr_t'(BUF_BYTES));
  assign buf_first = IDX_W'((buf_start - BUF_BASE) >> 2);
  assign last_idx  = IW1'((nbytes >> 2) - xaddr_t'(1));

  assign mem_req   = (st == ST_MOVE);
  assign mem_we    = dir;
  assign mem_addr  = ext_mask(ext_base + XA_W'({widx, 2'b00}), EXT_MASK_W);
  assign mem_wdata = buf_rdata;
  assign word_fire = mem_req && mem_ack;

  assign buf_idx   = buf_first + widx[IDX_W-1:0];
  assign buf_we    = word_fire && !dir;
  assign buf_wdata = mem_rdata;

  assign ev_abort  = (st == ST_CHECK) && !win_ok;
  assign ev_done   = (st == ST_FIN);
  assign irq       = ev_done && ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      dly  <= '0;
      widx <= '0;
    end else begin
      case (st)
        ST_IDLE: if (ev_start) begin
          st  <= ST_WAIT;
          dly <= '0;
        end
        ST_WAIT: begin
          if (dly == DLY_W'(START_DELAY - 1)) st <= ST_CHECK;
          else dly <= dly + 1'b1;
        end
        ST_CHECK: begin
          widx <= '0;
          st   <= win_ok ? ST_MOVE : ST_IDLE;
        end
        ST_MOVE: if (word_fire) begin
          if (widx == last_idx) st <= ST_FIN;
          else widx <= widx + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_lbuf_engine.sv
module dma_lbuf_engine
  import dma_lbuf_pkg::*;
#(
  parameter int     START_DELAY = 16,
  parameter xaddr_t BUF_BASE    = 64'h40000,
  parameter int     BUF_BYTES   = 4096,
  parameter int     EXT_MASK_W  = 28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_wide,
  input  logic [7:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        dma_irq
);
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int IDX_W     = $clog2(BUF_WORDS);
  localparam int DLY_W     = $clog2(START_DELAY + 1);

  xaddr_t           src_q, dst_q, cnt_q;
  logic             run_q, dir_q, ien_q, err_q;
  logic             ev_start, ev_done, ev_abort;
  logic             buf_we;
  logic [IDX_W-1:0] buf_idx;
  logic [31:0]      buf_wdata, buf_rdata;

  dma_lbuf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_done(ev_done), .ev_abort(ev_abort),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q),
    .run_q(run_q), .dir_q(dir_q), .ien_q(ien_q), .err_q(err_q),
    .ev_start(ev_start)
  );

  dma_lbuf_seq #(
    .START_DELAY(START_DELAY), .BUF_BASE(BUF_BASE), .BUF_BYTES(BUF_BYTES),
    .EXT_MASK_W(EXT_MASK_W), .IDX_W(IDX_W), .DLY_W(DLY_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start),
    .dir(dir_q), .ien(ien_q), .src(src_q), .dst(dst_q), .cnt(cnt_q),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .ev_done(ev_done), .ev_abort(ev_abort),
    .irq(dma_irq)
  );

  dma_lbuf_ram #(.WORDS(BUF_WORDS), .IDX_W(IDX_W), .DW(32)) u_ram (
    .clk(clk), .we(buf_we), .widx(buf_idx), .wdata(buf_wdata),
    .ridx(buf_idx), .rdata(buf_rdata)
  );
endmodule

// File: rtl/dma_lbuf_engine_chk.sv
module dma_lbuf_engine_chk #(
  parameter int START_DELAY = 16,
  parameter int EXT_MASK_W  = 28
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_start,
  input logic        ev_done,
  input logic        ev_abort,
  input logic        run_q,
  input logic        ien_q,
  input logic        err_q,
  input logic [63:0] src_q,
  input logic [63:0] dst_q,
  input logic [63:0] cnt_q,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [63:0] mem_addr,
  input logic        dma_irq
);
  localparam logic [63:0] EMASK =
    (EXT_MASK_W >= 64) ? '1 : ((64'd1 << EXT_MASK_W) - 64'd1);

  logic [31:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n) since <= '0;
    else if (ev_start) since <= 32'd1;
    else if (since != '1) since <= since + 32'd1;
  end

  p_regs_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(src_q) && $stable(dst_q) && $stable(cnt_q));
  p_start_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> run_q && !err_q);
  p_start_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> since >= 32'(START_DELAY + 2));
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> err_q && !run_q && !mem_req);
  p_ext_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr & ~EMASK) == 64'd0);
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_irq |-> ien_q && run_q);
  p_run_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> !run_q && !dma_irq);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
endmodule

bind dma_lbuf_engine dma_lbuf_engine_chk #(
  .START_DELAY(START_DELAY), .EXT_MASK_W(EXT_MASK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_done(ev_done),
  .ev_abort(ev_abort), .run_q(run_q), .ien_q(ien_q), .err_q(err_q),
  .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .dma_irq(dma_irq)
);

// File: tb/dma_lbuf_engine_tb_top.sv
module dma_lbuf_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 16;
  localparam logic [63:0] WBASE = 64'h40000;
  localparam logic [63:0] MASK  = 64'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_wide = 1'b1;
  logic [7:0]  reg_addr = 8'h0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic        dma_irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_lbuf_engine #(.START_DELAY(DLY), .EXT_MASK_W(28)) dut_i (.*);

  int checks = 0, errors = 0;
  bit done_flag = 0;
  logic [31:0] xmem [1024];
  logic [31:0] mb   [1024];
  int ack_wait = 1, wc = 0;
  int req_cycles = 0, irq_cnt = 0;
  bit hi_seen = 0;

  // external memory responder and event counters
  always @(negedge clk) begin
    if (mem_req) req_cycles++;
    if (dma_irq) irq_cnt++;
    if (mem_ack) begin
      mem_ack = 1'b0;
      wc = 0;
    end else if (mem_req) begin
      if (wc >= ack_wait) begin
        mem_ack = 1'b1;
        if (mem_addr[63:28] != '0) hi_seen = 1;
        if (mem_we) xmem[mem_addr[11:2]] = mem_wdata;
        else mem_rdata = xmem[mem_addr[11:2]];
      end else wc++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input bit wide);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wide = wide; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wide = 1'b1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [63:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h98, v);
      if (!v[0]) break;
    end
  endtask

  function automatic int bidx(input logic [63:0] a);
    return int'(((a & ~64'h3) - WBASE) >> 2);
  endfunction

  function automatic int xidx(input logic [63:0] a);
    return int'(((a & MASK) >> 2) & 64'h3FF);
  endfunction

  typedef struct packed {
    logic dir; logic ien; logic ok;
    logic [63:0] src; logic [63:0] dst; logic [63:0] cnt;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b1, 1'b1, 64'h40,          64'h40000,       64'd32},
    '{1'b1, 1'b0, 1'b1, 64'h40000,       64'h800,         64'd32},
    '{1'b0, 1'b1, 1'b1, 64'hF000_0080,   64'h40FF0,       64'd16},
    '{1'b1, 1'b1, 1'b1, 64'h40FF0,       64'h1000_0C00,   64'd19},
    '{1'b0, 1'b1, 1'b0, 64'h0,           64'h40FF8,       64'd16},
    '{1'b1, 1'b1, 1'b0, 64'h3FFFC,       64'h0,           64'd4},
    '{1'b0, 1'b1, 1'b0, 64'h0,           64'h40000,       64'd3},
    '{1'b1, 1'b0, 1'b1, 64'h40002,       64'h1000_0E00,   64'd8}
  };

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    int r0, i0, first, nw, bi, xi;
    for (int i = 0; i < 1024; i++) xmem[i] = 32'h5A00_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(8'h80, v); chk(v == 0, "R1 reset src", v, 0);
    rd(8'h98, v); chk(v == 0, "R1 reset cmd", v, 0);
    chk(!mem_req && !dma_irq, "R10 reset outputs", {mem_req, dma_irq}, 0);

    // R1 register widths and unmapped offsets
    wr(8'h80, 64'h1234_5678_9ABC_DEF0, 1);
    rd(8'h80, v); chk(v == 64'h1234_5678_9ABC_DEF0, "R1 wide write", v, 64'h1234_5678_9ABC_DEF0);
    wr(8'h88, 64'hFFFF_FFFF_0000_1111, 0);
    rd(8'h88, v); chk(v == 64'h1111, "R1 narrow write", v, 64'h1111);
    rd(8'h40, v); chk(v == '1, "R1 unmapped read", v, '1);

    // R3 command without run bit is discarded
    r0 = req_cycles;
    wr(8'h98, 64'h6, 1);
    repeat (DLY + 6) @(negedge clk);
    rd(8'h98, v); chk(v == 0, "R3 cmd without run", v, 0);
    chk(req_cycles == r0, "R3 no request", req_cycles, r0);

    // vector table
    for (int k = 0; k < 8; k++) begin
      r0 = req_cycles; i0 = irq_cnt;
      nw = int'(VEC[k].cnt >> 2);
      if (VEC[k].ok && !VEC[k].dir) begin
        bi = bidx(VEC[k].dst); xi = xidx(VEC[k].src);
        for (int w = 0; w < nw; w++) mb[bi + w] = xmem[xi + w];
      end
      wr(8'h80, VEC[k].src, 1);
      wr(8'h88, VEC[k].dst, 1);
      wr(8'h90, VEC[k].cnt, 1);
      wr(8'h98, {61'd0, VEC[k].ien, VEC[k].dir, 1'b1}, 1);
      wait_idle();
      rd(8'h98, v);
      chk(v[0] == 1'b0, $sformatf("R10 run cleared v%0d", k), v, 0);
      chk(v[31] == !VEC[k].ok, $sformatf("R8 R7 error flag v%0d", k), v[31], !VEC[k].ok);
      chk(v[2:1] == {VEC[k].ien, VEC[k].dir}, $sformatf("R3 cmd fields v%0d", k), v[2:1], {VEC[k].ien, VEC[k].dir});
      chk((irq_cnt - i0) == int'(VEC[k].ok && VEC[k].ien), $sformatf("R10 irq count v%0d", k),
          irq_cnt - i0, VEC[k].ok && VEC[k].ien);
      if (!VEC[k].ok)
        chk(req_cycles == r0, $sformatf("R8 no request v%0d", k), req_cycles - r0, 0);
      if (VEC[k].ok && VEC[k].dir) begin
        bi = bidx(VEC[k].src); xi = xidx(VEC[k].dst);
        for (int w = 0; w < nw; w++)
          chk(xmem[xi + w] === mb[bi + w], $sformatf("R5 R6 R12 word v%0d w%0d", k, w), xmem[xi + w], mb[bi + w]);
        chk(xmem[xi + nw] == 32'h5A00_0000 + xi + nw, $sformatf("R11 guard word v%0d", k),
            xmem[xi + nw], 32'h5A00_0000 + xi + nw);
      end
    end
    chk(!hi_seen, "R9 masked addresses", hi_seen, 0);

    // R4 start delay measured to the first request
    wr(8'h80, 64'h40000, 1);
    wr(8'h88, 64'hA00, 1);
    wr(8'h90, 64'd4, 1);
    wr(8'h98, 64'h3, 1);
    first = -1;
    for (int c = 1; c < 100; c++) begin
      #1;
      if (mem_req) begin first = c; break; end
      @(negedge clk);
    end
    chk(first == DLY + 2, "R4 first request cycle", first, DLY + 2);
    wait_idle();

    // R2 writes discarded while running
    wr(8'h98, 64'h3, 1);
    wr(8'h80, 64'h40010, 1);
    wr(8'h98, 64'h1, 1);
    rd(8'h80, v); chk(v == 64'h40000, "R2 src locked", v, 64'h40000);
    rd(8'h98, v); chk(v[1:0] == 2'b11, "R2 cmd locked", v, 3);
    wait_idle();
    rd(8'h98, v); chk(v[0] == 1'b0, "R2 completes", v, 0);
    chk(xmem[640] === mb[0], "R2 R6 copied word", xmem[640], mb[0]);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule